// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM with a built-in burst address generator. Every control and data input is sampled on the rising clock edge. Output enable is the exception: it acts at once, without waiting for a clock edge.

An access starts when one of two active-low address strobes is asserted. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls sampled on the same edge. After the first beat, a two-bit burst counter supplies the next word offsets. The counter steps only when the advance input is low. A mode input chooses linear or interleaved order.

Writes take their address, data and lane mask from registers and complete on the following edge. They cover selected byte lanes, or every lane under a global write. Reads pass through a registered array stage. A read issued on one edge therefore shows its word after the next edge, so a four-beat burst delivers one word per cycle once the first word arrives. High impedance is represented by an all-zero data bus together with a cleared output-valid flag.

Top module: `burst_sram`

## Requirements
- R1: A new external address is loaded only on an edge where a strobe starts an access. With no strobe and no burst in progress, no read or write takes place and `rvalid` stays low.
- R2: When the processor strobe is low and the chip is selected, a read starts at `addr` even if write controls are asserted. This strobe wins over a simultaneous controller strobe. While the chip is deselected it is ignored and any burst in progress carries on unchanged. The chip is selected when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0.
- R3: A controller strobe with the chip selected starts an access at `addr`. The access is a write when the write controls ask for one (R7, R8) and a read otherwise.
- R4: During a burst, on an edge with no strobe, `adv_n`=0 steps the two-bit counter by one. `adv_n`=1 repeats the current word, which is read again or, if write controls are asserted, written.
- R5: With `burst_mode`=0 (linear), beat offset = (start[1:0] + count) mod 4. The address bits above bit 1 stay fixed for the whole burst.
- R6: With `burst_mode`=1 (interleaved), beat offset = start[1:0] XOR count. The upper address bits stay fixed.
- R7: With `global_wr_n`=1 and `byte_wr_n`=0, lane i (data bits i*8+7..i*8) is written when `lane_en_n[i]`=0, and the other lanes keep their value. If no lane is enabled, the beat is a read.
- R8: `global_wr_n`=0 writes all lanes, whatever `byte_wr_n` and `lane_en_n` say.
- R9: A read issued on edge k shows its word on `rdata`, with `rvalid`=1, after edge k+1, provided `oe_n`=0.
- R10: `rdata` is zero and `rvalid` is low whenever `oe_n`=1 (this acts asynchronously), and after any edge whose preceding edge issued a write or no access.
- R11: A controller strobe with the chip deselected ends the burst. `rvalid` falls after the next edge, and the advance input has no effect until a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline state |
| addr | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_mode | input | 1 | 0 selects linear order, 1 selects interleaved order |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| global_wr_n | input | 1 | Global write of every lane, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wdata | input | DATA_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid (stands in for driven bus) |

## Verification
On every cycle, the assertions check the following:
- a processor-strobe start never writes;
- a global write on a controller start covers every lane;
- the counter steps by exactly one on an advancing beat;
- `rvalid` rises only after the pipeline stage held a read;
- a deselect clears `rvalid` two edges later.

Other behaviour can only be shown by the bench's scenarios, because only they compare data against a behavioural array:
- the actual word sequence of both burst orders from every starting offset;
- the merging of partial byte writes;
- a processor strobe that is ignored while the chip is deselected;
- the timing of output enable between clock edges.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Offset of a beat within the four-word block for a given start and count.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] count,
                                              input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ count;
    else            r = start + count;
    return r;
  endfunction

  // Lane mask requested by the write controls (all ones under a global write).
  function automatic logic [3:0] write_lanes(input logic       global_n,
                                             input logic       bytes_n,
                                             input logic [3:0] lanes_n);
    logic [3:0] m;
    if (!global_n)     m = 4'hF;
    else if (!bytes_n) m = ~lanes_n;
    else               m = 4'h0;
    return m;
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              burst_mode,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              global_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc_start_proc,
  output logic              acc_start_ctrl,
  output logic              acc_deselect,
  output logic              acc_continue,
  output logic              acc_write,
  output logic [LANES-1:0]  acc_mask,
  output logic [1:0]        burst_cnt,
  output logic              burst_active,
  output logic              s1_write,
  output logic              s1_read,
  output logic [LANES-1:0]  s1_mask,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [DATA_W-1:0] s1_data
);

  logic              selected, acc_start, acc_valid, cnt_step;
  logic [3:0]        lanes_n_ext, req_mask4;
  logic [LANES-1:0]  req_mask;
  logic [1:0]        cnt_nx;
  logic [ADDR_W-1:0] base_addr, base_nx, acc_addr;
  logic              s1_valid;

  assign selected       = !sel_a_n && sel_b && !sel_c_n;
  assign acc_start_proc = !proc_strobe_n && selected;
  assign acc_start_ctrl = !ctrl_strobe_n && selected && !acc_start_proc;
  assign acc_deselect   = !ctrl_strobe_n && !selected;
  assign acc_start      = acc_start_proc || acc_start_ctrl;
  assign acc_continue   = burst_active && !acc_start && !acc_deselect;
  assign acc_valid      = acc_start || acc_continue;

  // Widen the lane enables to four bits, padding unused lanes as disabled.
  generate
    if (LANES == 4) begin : g_four
      assign lanes_n_ext = lane_en_n;
      assign req_mask    = req_mask4;
    end else begin : g_two
      assign lanes_n_ext = {2'b11, lane_en_n};
      assign req_mask    = req_mask4[1:0];
    end
  endgenerate

  assign req_mask4 = write_lanes(global_wr_n, byte_wr_n, lanes_n_ext);

  assign cnt_step  = acc_continue && !adv_n;
  assign cnt_nx    = acc_start ? 2'd0 : burst_cnt + {1'b0, cnt_step};
  assign base_nx   = acc_start ? addr : base_addr;
  assign acc_addr  = {base_nx[ADDR_W-1:2], burst_offset(base_nx[1:0], cnt_nx, burst_mode)};
  assign acc_write = acc_valid && !acc_start_proc && (|req_mask);
  assign acc_mask  = acc_write ? req_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_active <= 1'b0;
      burst_cnt    <= 2'd0;
      base_addr    <= '0;
      s1_valid     <= 1'b0;
      s1_write     <= 1'b0;
    end else begin
      if (acc_start)         burst_active <= 1'b1;
      else if (acc_deselect) burst_active <= 1'b0;
      if (acc_valid) begin
        burst_cnt <= cnt_nx;
        base_addr <= base_nx;
      end
      s1_valid <= acc_valid;
      s1_write <= acc_write;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= acc_addr;
    s1_mask <= acc_mask;
    s1_data <= wdata;
  end

  assign s1_read = s1_valid && !s1_write;

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_mask[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
      end
    end
    if (rd_en) q <= mem[acc_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= rd_en;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              burst_mode,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              global_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic              acc_start_proc, acc_start_ctrl, acc_deselect, acc_continue, acc_write;
  logic [LANES-1:0]  acc_mask, s1_mask;
  logic [1:0]        burst_cnt;
  logic              burst_active, s1_write, s1_read, q_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data, q;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n),
    .burst_mode(burst_mode), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .global_wr_n(global_wr_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n), .wdata(wdata),
    .acc_start_proc(acc_start_proc), .acc_start_ctrl(acc_start_ctrl),
    .acc_deselect(acc_deselect), .acc_continue(acc_continue),
    .acc_write(acc_write), .acc_mask(acc_mask),
    .burst_cnt(burst_cnt), .burst_active(burst_active),
    .s1_write(s1_write), .s1_read(s1_read), .s1_mask(s1_mask),
    .s1_addr(s1_addr), .s1_data(s1_data)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(s1_write), .wr_mask(s1_mask),
    .acc_addr(s1_addr), .wr_data(s1_data), .rd_en(s1_read),
    .q(q), .q_valid(q_valid)
  );

  assign rvalid = q_valid && !oe_n;
  assign rdata  = rvalid ? q : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_n,
  input logic              global_wr_n,
  input logic              oe_n,
  input logic              rvalid,
  input logic              acc_start_proc,
  input logic              acc_start_ctrl,
  input logic              acc_deselect,
  input logic              acc_continue,
  input logic              acc_write,
  input logic [LANES-1:0]  acc_mask,
  input logic [1:0]        burst_cnt,
  input logic              s1_read
);

  // R2: processor-strobe start is always a read
  assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start_proc |-> !acc_write);

  // R8: global write on a controller start covers all lanes
  assert_global_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start_ctrl && !global_wr_n) |-> (acc_write && (&acc_mask)));

  // R4: an advancing beat steps the counter by one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_continue && !adv_n) |=> (burst_cnt == 2'($past(burst_cnt) + 2'd1)));

  // R4: a held beat keeps the counter
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_continue && adv_n) |=> $stable(burst_cnt));

  // R9: valid output only follows a read held in the pipeline stage
  assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(s1_read));

  // R9: a read in the pipeline stage shows up next cycle when enabled
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_read |=> (rvalid || oe_n));

  // R11: deselect drops the output after one more edge
  assert_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deselect |=> ##1 !rvalid);

endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W), .LANES(LANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .global_wr_n(global_wr_n), .oe_n(oe_n),
  .rvalid(rvalid), .acc_start_proc(acc_start_proc), .acc_start_ctrl(acc_start_ctrl),
  .acc_deselect(acc_deselect), .acc_continue(acc_continue), .acc_write(acc_write),
  .acc_mask(acc_mask), .burst_cnt(burst_cnt), .s1_read(s1_read)
);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        proc_strobe_n, ctrl_strobe_n, adv_n, burst_mode = 1'b0;
  logic        sel_a_n, sel_b, sel_c_n, global_wr_n, byte_wr_n, oe_n;
  logic [3:0]  lane_en_n;
  logic [31:0] wdata = '0, rdata;
  logic        rvalid;

  logic [31:0] model [64];
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .adv_n(adv_n), .burst_mode(burst_mode),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .global_wr_n(global_wr_n),
    .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_in();
    proc_strobe_n = 1; ctrl_strobe_n = 1; adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    global_wr_n = 1; byte_wr_n = 1; lane_en_n = 4'hF; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic logic [5:0] beat_addr(input logic [5:0] s, input int b, input logic il);
    int off;
    off = il ? ((s[1:0] & 3) ^ b) : ((s[1:0] + b) % 4);
    return {s[5:2], off[1:0]};
  endfunction

  task automatic t_reset();
    idle_in(); rst_n = 0;
    tick(); tick();
    check("R10 reset rvalid", {31'd0, rvalid}, 32'd0);
    check("R10 reset rdata", rdata, 32'd0);
    rst_n = 1; tick();
    check("R1 no access without strobe", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 64; a++) begin
      idle_in(); ctrl_strobe_n = 0; global_wr_n = 0; byte_wr_n = 0; lane_en_n = 4'hF;
      addr = 6'(a); wdata = 32'h5A000000 ^ (32'(a) * 32'h00010203);
      model[a] = wdata;
      tick();
    end
    idle_in(); tick();
  endtask

  task automatic t_burst_read(input logic [5:0] s, input logic il, input bit use_proc);
    string req;
    req = il ? "R6 interleaved" : "R5 linear";
    idle_in(); burst_mode = il; addr = s;
    if (use_proc) proc_strobe_n = 0; else ctrl_strobe_n = 0;
    tick();
    idle_in(); adv_n = 0;
    for (int b = 0; b < 3; b++) begin
      tick();
      check(req, rdata, model[beat_addr(s, b, il)]);
      if (b == 0) check("R9 first word valid", {31'd0, rvalid}, 32'd1);
    end
    adv_n = 1; tick();
    check(req, rdata, model[beat_addr(s, 3, il)]);
  endtask

  task automatic t_burst_write(input logic [5:0] s);
    idle_in(); burst_mode = 0; addr = s; ctrl_strobe_n = 0; byte_wr_n = 0; lane_en_n = 4'h0;
    for (int b = 0; b < 4; b++) begin
      wdata = 32'hC0DE0000 + 32'(b * 17 + s);
      model[beat_addr(s, b, 1'b0)] = wdata;
      tick();
      ctrl_strobe_n = 1; adv_n = 0;
    end
    idle_in(); tick();
    check("R10 write pending clears rvalid", {31'd0, rvalid}, 32'd0);
    tick();
    check("R4 hold repeats last word", rdata, model[beat_addr(s, 3, 1'b0)]);
    t_burst_read(s, 1'b0, 1'b0);
  endtask

  task automatic rd1(input logic [5:0] a, input string req);
    idle_in(); ctrl_strobe_n = 0; addr = a; tick();
    idle_in(); tick();
    check(req, rdata, model[a]);
  endtask

  task automatic t_lanes();
    // lanes 0 and 2 enabled
    idle_in(); ctrl_strobe_n = 0; addr = 6'd9; byte_wr_n = 0; lane_en_n = 4'b1010;
    wdata = 32'h11223344;
    model[9] = {model[9][31:24], 8'h22, model[9][15:8], 8'h44};
    tick(); idle_in(); tick();
    rd1(6'd9, "R7 partial lanes");
    // no lane enabled: beat is a read, nothing written
    idle_in(); ctrl_strobe_n = 0; addr = 6'd9; byte_wr_n = 0; lane_en_n = 4'hF; wdata = 32'hFFFFFFFF;
    tick(); idle_in(); tick();
    check("R7 no lane means read", rdata, model[9]);
    // global write overrides byte controls
    idle_in(); ctrl_strobe_n = 0; addr = 6'd10; global_wr_n = 0; byte_wr_n = 0; lane_en_n = 4'b1110;
    wdata = 32'hA1B2C3D4; model[10] = wdata;
    tick(); idle_in(); tick();
    rd1(6'd10, "R8 global write all lanes");
  endtask

  task automatic t_proc_rules();
    // write controls ignored with processor strobe
    idle_in(); proc_strobe_n = 0; addr = 6'd12; global_wr_n = 0; wdata = 32'hDEADBEEF;
    tick(); idle_in(); tick();
    check("R2 proc strobe reads", rdata, model[12]);
    // priority over controller strobe
    idle_in(); proc_strobe_n = 0; ctrl_strobe_n = 0; addr = 6'd13; global_wr_n = 0; wdata = 32'hDEADBEEF;
    tick(); idle_in(); tick();
    check("R2 proc priority", rdata, model[13]);
    rd1(6'd13, "R2 no write on priority");
    // ignored while deselected
    idle_in(); ctrl_strobe_n = 0; burst_mode = 0; addr = 6'd20; tick();
    idle_in(); proc_strobe_n = 0; sel_b = 0; addr = 6'd40; tick();
    check("R3 controller read", rdata, model[20]);
    idle_in(); adv_n = 0; tick();
    check("R2 deselected proc ignored", rdata, model[20]);
    idle_in(); tick();
    check("R2 burst continues", rdata, model[21]);
  endtask

  task automatic t_suspend();
    idle_in(); burst_mode = 0; ctrl_strobe_n = 0; addr = 6'd30; tick();
    idle_in(); adv_n = 0; tick();
    check("R4 beat0", rdata, model[30]);
    adv_n = 1; tick();
    check("R4 beat1", rdata, model[31]);
    adv_n = 0; tick();
    check("R4 beat1 held", rdata, model[31]);
    tick();
    check("R4 beat2 wraps", rdata, model[28]);
  endtask

  task automatic t_deselect();
    idle_in(); ctrl_strobe_n = 0; addr = 6'd5; tick();
    idle_in(); ctrl_strobe_n = 0; sel_a_n = 1; tick();
    check("R11 last word still out", rdata, model[5]);
    idle_in(); adv_n = 0; tick();
    check("R11 rvalid drops", {31'd0, rvalid}, 32'd0);
    check("R10 rdata zero", rdata, 32'd0);
    tick();
    check("R11 advance ignored", {31'd0, rvalid}, 32'd0);
    idle_in(); tick();
    check("R1 stays idle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_oe();
    idle_in(); ctrl_strobe_n = 0; addr = 6'd33; tick();
    idle_in(); tick();
    oe_n = 1; #1;
    check("R10 oe high rvalid", {31'd0, rvalid}, 32'd0);
    check("R10 oe high rdata", rdata, 32'd0);
    oe_n = 0; #1;
    check("R10 oe low again", rdata, model[33]);
  endtask

  initial begin
    t_reset();
    t_fill();
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 4; o++)
        t_burst_read(6'((m * 24) + 8 + o), 1'(m), (o % 2) == 1);
    t_burst_write(6'd46);
    t_lanes();
    t_proc_rules();
    t_suspend();
    t_deselect();
    t_oe();
    summary();
  end

endmodule